// File: doc/BRIEF.md
# Context-Tagged Translation Buffer

This block caches virtual-to-physical page translations for a 32-bit address space with 8 KiB pages. Each of its 64 entries holds a virtual page number, a physical frame number, four permission and state flags, and a 6-bit address-space tag. The entries are arranged as 16 groups of 4 ways; a lookup examines only the group picked by the low four bits of its virtual page number. A lookup hits when the entry is valid, its stored page number equals the requested one, and either its tag equals the running-context register or it is marked global. The largest tag value is reserved: the context register refuses it, so entries carrying that tag can never hit, which lets software park an entry in an inert state.

Software reaches the contents through a four-register window. It writes an entry index into the select register, then reads or writes that entry's high word (tag and virtual page) and low word (frame and flags). The fourth window register holds the running context. The lookup port is combinational: it takes an address, a write flag and a user-mode flag, and returns hit, miss, frame number and a protection fault. Refill policy, table walking and exception delivery are left to the surrounding logic.

Top module: `ctx_tlb`

## Requirements
- R1: The register window is addressed by `reg_sel`: 0 = entry select, 1 = high word, 2 = low word, 3 = running context. A write (`reg_we` high) takes effect at the next rising clock edge; `reg_rdata` always shows the addressed register's current contents.
- R2: The high word holds the virtual page number in bits [31:13] and the address-space tag in bits [5:0]; bits [12:6] read as zero.
- R3: The low word holds the frame number in bits [31:13] and the flags write-enable in bit 0, kernel-only in bit 1, valid in bit 2 and global in bit 3; bits [12:4] read as zero.
- R4: After reset the select and context registers read 0, and every entry reads with tag 63, virtual page equal to its index bits [3:0], and a low word of zero.
- R5: A lookup hits only when an entry is valid, its virtual page equals address bits [31:13], and its tag equals the running context (or the entry is global); the frame number of the hit is returned.
- R6: A valid entry with the global flag set hits regardless of its tag and of the running context.
- R7: A write of 63 to the context register is ignored, so a non-global entry tagged 63 never hits.
- R8: Entry index bits [5:4] give the way and bits [3:0] the group; a lookup considers only the four entries of group vpn[3:0], so an entry placed in another group never hits.
- R9: On a hit, a user-mode access to a kernel-only page or a write to a page with write-enable clear raises the fault output; no fault is raised otherwise.
- R10: When no entry hits, miss is high, hit is low, the frame output is zero and fault is low.
- R11: A lookup in the same cycle as a register write sees the contents from before the write.
- R12: When several ways of one group hit, the lowest-numbered way supplies the frame and flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Write strobe for the register window |
| reg_sel | input | 2 | Window register address |
| reg_wdata | input | 32 | Write data for the window |
| reg_rdata | output | 32 | Current contents of the addressed window register |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup is made in user mode |
| lk_hit | output | 1 | A matching entry was found |
| lk_miss | output | 1 | No matching entry was found |
| lk_pfn | output | 19 | Frame number of the matching entry, zero on miss |
| lk_fault | output | 1 | Protection fault on a hit |

## Verification
A corrupted entry, tag or context value shows at the lookup port in the same cycle it exists, as a wrong hit, a missed hit, a wrong frame or a wrong fault, and at `reg_rdata` as soon as the window is pointed at it. A register update landing a cycle early or late shows as a lookup during the write cycle returning the new contents, or as the cycle after the write still returning the old ones. A wrong group or way decode shows as entries hitting from outside their group or the wrong way winning a multiple hit.

// File: rtl/ctx_tlb_pkg.sv
// Shared definitions for the context-tagged translation buffer.
// Assumes the register window is 2 bits wide and flags sit in the low nibble.
package ctx_tlb_pkg;

    typedef enum logic [1:0] {
        WIN_SELECT = 2'd0,
        WIN_HI     = 2'd1,
        WIN_LO     = 2'd2,
        WIN_CTX    = 2'd3
    } win_e;

    localparam int FLAG_WE     = 0;
    localparam int FLAG_KERN   = 1;
    localparam int FLAG_VALID  = 2;
    localparam int FLAG_GLOBAL = 3;
    localparam int FLAG_W      = 4;

endpackage

// File: rtl/ctx_tlb_regs.sv
// Entry-select and running-context registers of the window.
// Assumes the reserved tag is the all-ones value; a write of it to the
// context register is dropped so that value never becomes current.
module ctx_tlb_regs #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int ASID_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  sel_q,
    output logic [ASID_W-1:0] ctx_q
);
    import ctx_tlb_pkg::*;

    localparam logic [ASID_W-1:0] RESERVED = '1;

    logic [ASID_W-1:0] ctx_new;
    assign ctx_new = wdata[ASID_W-1:0];

    // Latch the entry index written through the select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (we && win_e'(sel) == WIN_SELECT) begin
            sel_q <= wdata[IDX_W-1:0];
        end
    end

    // Latch the running context, refusing the reserved tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else if (we && win_e'(sel) == WIN_CTX && ctx_new != RESERVED) begin
            ctx_q <= ctx_new;
        end
    end

endmodule

// File: rtl/ctx_tlb_store.sv
// Entry storage: tag, virtual page, frame and flags for every entry.
// Assumes writes address one entry through idx; reset parks each entry
// with the reserved tag and a page number equal to its group index.
module ctx_tlb_store #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6,
    parameter int GRP_W   = 4,
    parameter int ASID_W  = 6,
    parameter int VPN_W   = 19,
    parameter int PFN_W   = 19,
    parameter int FLAG_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_hi,
    input  logic                            wr_lo,
    input  logic [IDX_W-1:0]                idx,
    input  logic [ASID_W-1:0]               new_tag,
    input  logic [VPN_W-1:0]                new_vpn,
    input  logic [PFN_W-1:0]                new_pfn,
    input  logic [FLAG_W-1:0]               new_flags,
    output logic [ENTRIES-1:0][ASID_W-1:0]  tag_q,
    output logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q,
    output logic [ENTRIES-1:0][PFN_W-1:0]   pfn_q,
    output logic [ENTRIES-1:0][FLAG_W-1:0]  flags_q
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(e);
        localparam logic [VPN_W-1:0] PARK_VPN = VPN_W'(MY_IDX[GRP_W-1:0]);

        // High word of this entry: tag and virtual page.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[e] <= '1;
                vpn_q[e] <= PARK_VPN;
            end else if (wr_hi && idx == MY_IDX) begin
                tag_q[e] <= new_tag;
                vpn_q[e] <= new_vpn;
            end
        end

        // Low word of this entry: frame number and flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pfn_q[e]   <= '0;
                flags_q[e] <= '0;
            end else if (wr_lo && idx == MY_IDX) begin
                pfn_q[e]   <= new_pfn;
                flags_q[e] <= new_flags;
            end
        end
    end

endmodule

// File: rtl/ctx_tlb_match.sv
// Group lookup: compares the ways of the group picked by vpn[GRP_W-1:0]
// and returns the lowest hitting way's frame and flags.
// Assumes entry index = {way, group}.
module ctx_tlb_match #(
    parameter int ENTRIES = 64,
    parameter int WAYS    = 4,
    parameter int GRP_W   = 4,
    parameter int WAY_W   = 2,
    parameter int IDX_W   = 6,
    parameter int ASID_W  = 6,
    parameter int VPN_W   = 19,
    parameter int PFN_W   = 19,
    parameter int FLAG_W  = 4
) (
    input  logic [ENTRIES-1:0][ASID_W-1:0] tag_q,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q,
    input  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q,
    input  logic [ENTRIES-1:0][FLAG_W-1:0] flags_q,
    input  logic [VPN_W-1:0]               vpn,
    input  logic [ASID_W-1:0]              ctx,
    output logic                           hit,
    output logic [PFN_W-1:0]               pfn,
    output logic [FLAG_W-1:0]              flags
);
    import ctx_tlb_pkg::*;

    logic [GRP_W-1:0]  grp;
    logic [WAYS-1:0]   way_hit;
    logic [WAYS-1:0][PFN_W-1:0]  way_pfn;
    logic [WAYS-1:0][FLAG_W-1:0] way_flags;

    assign grp = vpn[GRP_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic [WAY_W-1:0] WV = WAY_W'(w);
        logic [IDX_W-1:0] ei;
        logic             tag_ok;

        // Compare one way of the selected group against the request.
        always_comb begin
            ei           = {WV, grp};
            tag_ok       = flags_q[ei][FLAG_GLOBAL] || (tag_q[ei] == ctx);
            way_hit[w]   = flags_q[ei][FLAG_VALID] && tag_ok && (vpn_q[ei] == vpn);
            way_pfn[w]   = pfn_q[ei];
            way_flags[w] = flags_q[ei];
        end
    end

    // Pick the lowest-numbered hitting way.
    always_comb begin
        hit   = 1'b0;
        pfn   = '0;
        flags = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                hit   = 1'b1;
                pfn   = way_pfn[w];
                flags = way_flags[w];
            end
        end
    end

endmodule

// File: rtl/ctx_tlb.sv
// Context-tagged translation buffer with an indirect register window.
// Assumes 32-bit addresses and words; page size set by PAGE_SHIFT, which
// must exceed ASID_W and the flag count so both words pack without overlap.
module ctx_tlb #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int ASID_W     = 6,
    parameter int SETS       = 16,
    parameter int WAYS       = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_we,
    input  logic [1:0]                     reg_sel,
    input  logic [ADDR_W-1:0]              reg_wdata,
    output logic [ADDR_W-1:0]              reg_rdata,
    input  logic [ADDR_W-1:0]              lk_vaddr,
    input  logic                           lk_write,
    input  logic                           lk_user,
    output logic                           lk_hit,
    output logic                           lk_miss,
    output logic [ADDR_W-PAGE_SHIFT-1:0]   lk_pfn,
    output logic                           lk_fault
);
    import ctx_tlb_pkg::*;

    localparam int ENTRIES = SETS * WAYS;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int GRP_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int VPN_W   = ADDR_W - PAGE_SHIFT;
    localparam int PFN_W   = VPN_W;
    localparam int HI_PAD  = PAGE_SHIFT - ASID_W;
    localparam int LO_PAD  = PAGE_SHIFT - FLAG_W;

    logic [IDX_W-1:0]                sel_q;
    logic [ASID_W-1:0]               ctx_q;
    logic [ENTRIES-1:0][ASID_W-1:0]  tag_q;
    logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
    logic [ENTRIES-1:0][PFN_W-1:0]   pfn_q;
    logic [ENTRIES-1:0][FLAG_W-1:0]  flags_q;
    logic                            wr_hi;
    logic                            wr_lo;
    logic                            m_hit;
    logic [PFN_W-1:0]                m_pfn;
    logic [FLAG_W-1:0]               m_flags;

    assign wr_hi = reg_we && win_e'(reg_sel) == WIN_HI;
    assign wr_lo = reg_we && win_e'(reg_sel) == WIN_LO;

    ctx_tlb_regs #(
        .DATA_W (ADDR_W),
        .IDX_W  (IDX_W),
        .ASID_W (ASID_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .sel_q (sel_q),
        .ctx_q (ctx_q)
    );

    ctx_tlb_store #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .GRP_W   (GRP_W),
        .ASID_W  (ASID_W),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .FLAG_W  (FLAG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .idx       (sel_q),
        .new_tag   (reg_wdata[ASID_W-1:0]),
        .new_vpn   (reg_wdata[ADDR_W-1:PAGE_SHIFT]),
        .new_pfn   (reg_wdata[ADDR_W-1:PAGE_SHIFT]),
        .new_flags (reg_wdata[FLAG_W-1:0]),
        .tag_q     (tag_q),
        .vpn_q     (vpn_q),
        .pfn_q     (pfn_q),
        .flags_q   (flags_q)
    );

    ctx_tlb_match #(
        .ENTRIES (ENTRIES),
        .WAYS    (WAYS),
        .GRP_W   (GRP_W),
        .WAY_W   (WAY_W),
        .IDX_W   (IDX_W),
        .ASID_W  (ASID_W),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .FLAG_W  (FLAG_W)
    ) u_match (
        .tag_q   (tag_q),
        .vpn_q   (vpn_q),
        .pfn_q   (pfn_q),
        .flags_q (flags_q),
        .vpn     (lk_vaddr[ADDR_W-1:PAGE_SHIFT]),
        .ctx     (ctx_q),
        .hit     (m_hit),
        .pfn     (m_pfn),
        .flags   (m_flags)
    );

    // Drive the lookup results and the protection check.
    always_comb begin
        lk_hit   = m_hit;
        lk_miss  = !m_hit;
        lk_pfn   = m_pfn;
        lk_fault = m_hit && ((lk_user && m_flags[FLAG_KERN]) ||
                             (lk_write && !m_flags[FLAG_WE]));
    end

    // Return the addressed window register.
    always_comb begin
        unique case (win_e'(reg_sel))
            WIN_SELECT: reg_rdata = ADDR_W'(sel_q);
            WIN_HI:     reg_rdata = {vpn_q[sel_q], {HI_PAD{1'b0}}, tag_q[sel_q]};
            WIN_LO:     reg_rdata = {pfn_q[sel_q], {LO_PAD{1'b0}}, flags_q[sel_q]};
            default:    reg_rdata = ADDR_W'(ctx_q);
        endcase
    end

endmodule

// File: rtl/ctx_tlb_chk.sv
// Property checker for ctx_tlb, attached by bind to every instance.
// Assumes it observes the window registers and lookup outputs only.
module ctx_tlb_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int ASID_W = 6,
    parameter int PFN_W  = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic [IDX_W-1:0]  sel_q,
    input logic [ASID_W-1:0] ctx_q,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_fault,
    input logic [PFN_W-1:0]  lk_pfn
);

    // Select write lands on the next edge.
    assert_sel_update_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd0) |=> (sel_q == $past(reg_wdata[IDX_W-1:0])));

    // A non-reserved context write lands on the next edge.
    assert_ctx_update_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd3 && reg_wdata[ASID_W-1:0] != '1)
        |=> (ctx_q == $past(reg_wdata[ASID_W-1:0])));

    // The reserved tag never becomes the running context.
    assert_ctx_not_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_q != '1);

    // A write of the reserved tag leaves the context untouched.
    assert_ctx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd3 && reg_wdata[ASID_W-1:0] == '1) |=> $stable(ctx_q));

    // A fault is only raised alongside a hit.
    assert_fault_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    // A miss returns frame zero and no fault.
    assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_pfn == '0 && !lk_fault));

endmodule

bind ctx_tlb ctx_tlb_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .ASID_W (ASID_W),
    .PFN_W  (PFN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .sel_q     (sel_q),
    .ctx_q     (ctx_q),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .lk_fault  (lk_fault),
    .lk_pfn    (lk_pfn)
);

// File: tb/sim_ctx_tlb.sv
// Directed bench for ctx_tlb: one task per scenario, each checking itself.
module sim_ctx_tlb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        lk_hit;
    logic        lk_miss;
    logic [18:0] lk_pfn;
    logic        lk_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ctx_tlb u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lk_vaddr  (lk_vaddr),
        .lk_write  (lk_write),
        .lk_user   (lk_user),
        .lk_hit    (lk_hit),
        .lk_miss   (lk_miss),
        .lk_pfn    (lk_pfn),
        .lk_fault  (lk_fault)
    );

    localparam logic [1:0] S_SEL = 2'd0, S_HI = 2'd1, S_LO = 2'd2, S_CTX = 2'd3;

    function automatic logic [31:0] mk_hi(input logic [5:0] tag, input logic [18:0] vpn);
        return {vpn, 7'b0, tag};
    endfunction

    function automatic logic [31:0] mk_lo(input logic [18:0] pfn, input logic g,
                                          input logic v, input logic k, input logic w);
        return {pfn, 9'b0, g, v, k, w};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] s, output logic [31:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic put_entry(input logic [5:0] idx, input logic [31:0] hi, input logic [31:0] lo);
        reg_wr(S_SEL, 32'(idx));
        reg_wr(S_HI, hi);
        reg_wr(S_LO, lo);
    endtask

    // Drive a lookup and return {hit, miss, fault, pfn}.
    task automatic look(input logic [18:0] vpn, input logic wr, input logic usr,
                        output logic [21:0] r);
        lk_vaddr = {vpn, 13'h0A4};
        lk_write = wr;
        lk_user  = usr;
        #1;
        r = {lk_hit, lk_miss, lk_fault, lk_pfn};
    endtask

    function automatic logic [21:0] expect_hit(input logic [18:0] pfn, input logic f);
        return {1'b1, 1'b0, f, pfn};
    endfunction

    localparam logic [21:0] MISS = {1'b0, 1'b1, 1'b0, 19'd0};

    task automatic t_reset;
        logic [31:0] d;
        reg_rd(S_SEL, d); check("R4 select after reset", d, 32'd0);
        reg_rd(S_CTX, d); check("R4 context after reset", d, 32'd0);
        reg_wr(S_SEL, 32'd37);
        reg_rd(S_SEL, d); check("R1 select readback", d, 32'd37);
        reg_rd(S_HI, d);  check("R4 parked high word", d, mk_hi(6'h3f, 19'd5));
        reg_rd(S_LO, d);  check("R4 parked low word", d, 32'd0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        logic [21:0] r;
        reg_wr(S_CTX, 32'd3);
        reg_rd(S_CTX, d); check("R1 context readback", d, 32'd3);
        put_entry(6'h15, mk_hi(6'd3, 19'h12345), mk_lo(19'h0ABCD, 0, 1, 0, 1));
        reg_rd(S_HI, d); check("R2 high word layout", d, mk_hi(6'd3, 19'h12345));
        reg_rd(S_LO, d); check("R3 low word layout", d, mk_lo(19'h0ABCD, 0, 1, 0, 1));
        look(19'h12345, 1'b1, 1'b1, r); check("R5 tagged hit", 32'(r), 32'(expect_hit(19'h0ABCD, 0)));
        look(19'h12355, 1'b0, 1'b0, r); check("R5 other page misses", 32'(r), 32'(MISS));
        reg_wr(S_CTX, 32'd4);
        look(19'h12345, 1'b0, 1'b0, r); check("R10 context mismatch misses", 32'(r), 32'(MISS));
    endtask

    task automatic t_global;
        logic [21:0] r;
        put_entry(6'h27, mk_hi(6'd9, 19'h00777), mk_lo(19'h01234, 1, 1, 0, 1));
        look(19'h00777, 1'b0, 1'b1, r); check("R6 global hit any context", 32'(r), 32'(expect_hit(19'h01234, 0)));
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        logic [21:0] r;
        reg_wr(S_CTX, 32'd63);
        reg_rd(S_CTX, d); check("R7 reserved context write ignored", d, 32'd4);
        put_entry(6'h12, mk_hi(6'd63, 19'h00062), mk_lo(19'h00333, 0, 1, 0, 1));
        look(19'h00062, 1'b0, 1'b0, r); check("R7 reserved tag never hits", 32'(r), 32'(MISS));
    endtask

    task automatic t_group;
        logic [21:0] r;
        put_entry(6'h03, mk_hi(6'd4, 19'h00004), mk_lo(19'h00444, 0, 1, 0, 1));
        look(19'h00004, 1'b0, 1'b0, r); check("R8 wrong group never hits", 32'(r), 32'(MISS));
        put_entry(6'h34, mk_hi(6'd4, 19'h00004), mk_lo(19'h00445, 0, 1, 0, 1));
        look(19'h00004, 1'b0, 1'b0, r); check("R8 way 3 of right group hits", 32'(r), 32'(expect_hit(19'h00445, 0)));
    endtask

    task automatic t_fault;
        logic [21:0] r;
        put_entry(6'h0C, mk_hi(6'd4, 19'h0003C), mk_lo(19'h00111, 0, 1, 1, 0));
        look(19'h0003C, 1'b0, 1'b1, r); check("R9 user read of kernel page", 32'(r), 32'(expect_hit(19'h00111, 1)));
        look(19'h0003C, 1'b0, 1'b0, r); check("R9 kernel read no fault", 32'(r), 32'(expect_hit(19'h00111, 0)));
        look(19'h0003C, 1'b1, 1'b0, r); check("R9 write without enable", 32'(r), 32'(expect_hit(19'h00111, 1)));
        put_entry(6'h1D, mk_hi(6'd4, 19'h0004D), mk_lo(19'h00222, 0, 1, 0, 1));
        look(19'h0004D, 1'b1, 1'b1, r); check("R9 user write allowed", 32'(r), 32'(expect_hit(19'h00222, 0)));
    endtask

    task automatic t_priority;
        logic [21:0] r;
        put_entry(6'h2A, mk_hi(6'd4, 19'h0007A), mk_lo(19'h00AA2, 0, 1, 0, 1));
        put_entry(6'h0A, mk_hi(6'd4, 19'h0007A), mk_lo(19'h00AA0, 0, 1, 0, 0));
        look(19'h0007A, 1'b0, 1'b0, r); check("R12 lowest way wins", 32'(r), 32'(expect_hit(19'h00AA0, 0)));
        look(19'h0007A, 1'b1, 1'b0, r); check("R12 flags from lowest way", 32'(r), 32'(expect_hit(19'h00AA0, 1)));
        reg_wr(S_LO, mk_lo(19'h00AA0, 0, 0, 0, 0));
        look(19'h0007A, 1'b0, 1'b0, r); check("R5 invalid entry skipped", 32'(r), 32'(expect_hit(19'h00AA2, 0)));
    endtask

    task automatic t_same_cycle;
        logic [21:0] r;
        put_entry(6'h1B, mk_hi(6'd4, 19'h0001B), mk_lo(19'h00055, 0, 0, 0, 1));
        @(negedge clk);
        reg_we = 1'b1; reg_sel = S_LO; reg_wdata = mk_lo(19'h00055, 0, 1, 0, 1);
        look(19'h0001B, 1'b0, 1'b0, r); check("R11 write cycle sees old entry", 32'(r), 32'(MISS));
        @(negedge clk);
        reg_we = 1'b0;
        look(19'h0001B, 1'b0, 1'b0, r); check("R11 next cycle sees new entry", 32'(r), 32'(expect_hit(19'h00055, 0)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_global();
        t_reserved();
        t_group();
        t_fault();
        t_priority();
        t_same_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule